// File: doc/BRIEF.md
# CMI Line Decoder and Word Deserializer

This block sits behind a clock and data recovery stage on an electrical or optical line port. Its clock runs at twice the line bit rate, so each line bit arrives as two successive samples, or half-bits. When CMI decoding is on, every pair of half-bits becomes one NRZ bit. Pairs that break the code rules raise a violation flag. When decoding is off, as on an optical link, the first sample of each pair is taken directly as the NRZ bit.

The decoded bits are packed into words of 2, 4 or 8 bits. The earliest bit goes to the lowest word bit. A parallel clock with a 50% duty cycle runs at the word rate. One of four quarter-period offsets can delay it. A remote loop control returns the received samples toward the line.

Word width and clock offset are captured while reset is high. The decode-enable and loop controls act at once.

Top module: `cmi_rx_deser`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `word_out` is 0, `viol_out` is 0 and `line_out` is 0. With offset code 0, `pclk_out` is 1.
- R2: With `cmi_en` high, a half-bit pair decodes as follows, written as (first sample, second sample). (0,1) gives 0. (0,0) and (1,1) each give 1.
- R3: The first bit received after reset goes to `word_out` bit 0, and later bits fill ascending positions. Bits at or above the selected width read 0.
- R4: Pair capture starts on the first clock edge after reset is released, and the first sample of every pair falls on an even edge. The width is W = 2, 4, 8, 8 for `width_sel` codes 0, 1, 2, 3. Word n (counting from 0) appears on `word_out` right after edge 2W(n+1)-1.
- R5: With `cmi_en` high, the pair (1,0) is a violation and decodes as 0.
- R6: With `cmi_en` high, a 1 symbol at the same level as the previous 1 symbol is a violation. This holds even when 0 symbols come between them. The first 1 symbol after reset, or after `cmi_en` rises, is never flagged.
- R7: `viol_out` is high exactly while the word on `word_out` holds at least one violating pair. The next clean word clears it.
- R8: With `cmi_en` low, each bit is the first sample of its pair and `viol_out` stays 0.
- R9: `pclk_out` has period 2W clock cycles and is high for W cycles. Take k as the number of edges since reset and s as `phase_sel`·W/2. Then `pclk_out` is 1 exactly when (k − s) mod 2W < W. This places the rising edge at 0°, 90°, 180° or 270° of the word period.
- R10: With `loop_en` high, `line_out` equals `line_in` as it was one clock earlier. With `loop_en` low, `line_out` is 0.
- R11: `width_sel` and `phase_sel` are captured only while `rst` is high. Changing them afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Recovered line sample |
| cmi_en | input | 1 | 1: decode CMI, 0: treat line as NRZ |
| loop_en | input | 1 | Remote loop enable |
| width_sel | input | 2 | Word width code, captured in reset |
| phase_sel | input | 2 | Parallel clock offset code (0..3 quarters), captured in reset |
| word_out | output | MAX_W | Deserialized word, earliest bit in bit 0 |
| viol_out | output | 1 | Current word contains a code violation |
| pclk_out | output | 1 | Parallel word clock |
| line_out | output | 1 | Looped-back line sample |

## Verification
A wrong half-bit phase would swap the sample roles in every pair, so every word after the first would carry false ones and false violations. Stale level memory for ones would show up as a spurious or missing `viol_out` on the very word holding the second one, or as a flag that leaks into the following clean word. A bit counter that drifts from the parallel clock counter would move the `word_out` update away from the 0° rising edge of `pclk_out`. The per-tick clock check would catch that within one word period.

// File: rtl/cmi_rx_pkg.sv
package cmi_rx_pkg;

    typedef enum logic [1:0] {
        WSEL_2  = 2'd0,
        WSEL_4  = 2'd1,
        WSEL_8  = 2'd2,
        WSEL_8B = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        SYM_ZERO,
        SYM_ONE_LO,
        SYM_ONE_HI,
        SYM_BAD
    } sym_e;

    typedef struct packed {
        logic valid;
        logic data;
        logic viol;
    } dbit_t;

    function automatic int unsigned width_of(input logic [1:0] code);
        case (wsel_e'(code))
            WSEL_2:  return 2;
            WSEL_4:  return 4;
            default: return 8;
        endcase
    endfunction

    function automatic sym_e classify(input logic first, input logic second);
        case ({first, second})
            2'b01:   return SYM_ZERO;
            2'b00:   return SYM_ONE_LO;
            2'b11:   return SYM_ONE_HI;
            default: return SYM_BAD;
        endcase
    endfunction

endpackage

// File: rtl/cmi_sym_dec.sv
module cmi_sym_dec
    import cmi_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_in,
    input  logic  cmi_en,
    output dbit_t dbit
);
    logic half;
    logic first_q;
    logic seen_one;
    logic last_lvl;
    sym_e sym;
    logic is_one;
    logic lvl;

    always_comb begin
        sym    = classify(first_q, line_in);
        is_one = (sym == SYM_ONE_LO) || (sym == SYM_ONE_HI);
        lvl    = (sym == SYM_ONE_HI);
        dbit.valid = half;
        dbit.data  = 1'b0;
        dbit.viol  = 1'b0;
        if (cmi_en) begin
            case (sym)
                SYM_ZERO:  dbit.data = 1'b0;
                SYM_BAD:   dbit.viol = 1'b1;
                default: begin
                    dbit.data = 1'b1;
                    dbit.viol = seen_one && (last_lvl == lvl);
                end
            endcase
        end else begin
            dbit.data = first_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half     <= 1'b0;
            first_q  <= 1'b0;
            seen_one <= 1'b0;
            last_lvl <= 1'b0;
        end else begin
            half <= ~half;
            if (!half) first_q <= line_in;
            if (!cmi_en) begin
                seen_one <= 1'b0;
            end else if (half && is_one) begin
                seen_one <= 1'b1;
                last_lvl <= lvl;
            end
        end
    end

    // R4: a decoded bit is produced on every second edge only
    p_half_alt_r4: assert property (@(posedge clk) disable iff (rst)
        half |=> !half);

    // R6: level memory becomes armed only after a decoded one
    p_arm_after_one_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(seen_one) |-> $past(half) && $past(cmi_en));

endmodule

// File: rtl/cmi_word_pack.sv
module cmi_word_pack
    import cmi_rx_pkg::*;
#(
    parameter int unsigned MAX_W = 8,
    localparam int unsigned IW = $clog2(MAX_W),
    localparam int unsigned LW = IW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  dbit_t            dbit,
    input  logic [LW-1:0]    wlen,
    output logic             done,
    output logic [MAX_W-1:0] word_out,
    output logic             word_viol
);
    logic [IW-1:0]    idx;
    logic [MAX_W-1:0] acc;
    logic [MAX_W-1:0] nxt;
    logic [MAX_W-1:0] lane_on;
    logic             vacc;

    assign done = dbit.valid && (idx == IW'(wlen - LW'(1)));

    for (genvar i = 0; i < MAX_W; i++) begin : g_lane
        assign lane_on[i] = (LW'(i) < wlen);
        assign nxt[i] = (dbit.valid && idx == IW'(i)) ? dbit.data : acc[i];
        always_ff @(posedge clk) begin
            if (rst) begin
                acc[i]      <= 1'b0;
                word_out[i] <= 1'b0;
            end else if (done) begin
                acc[i]      <= 1'b0;
                word_out[i] <= nxt[i] & lane_on[i];
            end else begin
                acc[i]      <= nxt[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            vacc      <= 1'b0;
            word_viol <= 1'b0;
        end else if (dbit.valid) begin
            if (done) begin
                idx       <= '0;
                vacc      <= 1'b0;
                word_viol <= vacc | dbit.viol;
            end else begin
                idx  <= idx + IW'(1);
                vacc <= vacc | dbit.viol;
            end
        end
    end

    // R3: lanes beyond the selected width never carry data
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (word_out & ~lane_on) == '0);

    // R7: a word finished with no violating pair clears the flag
    p_viol_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !vacc && !dbit.viol) |=> !word_viol);

endmodule

// File: rtl/cmi_pclk_gen.sv
module cmi_pclk_gen #(
    parameter int unsigned MAX_W = 8,
    localparam int unsigned LW = $clog2(MAX_W) + 1,
    localparam int unsigned TW = LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] wlen,
    input  logic [1:0]    phase,
    output logic [TW-1:0] tcnt,
    output logic          pclk
);
    logic [TW:0] span;
    logic [TW:0] quarter;
    logic [TW:0] shift;
    logic [TW:0] pos;

    always_comb begin
        span    = {1'b0, wlen, 1'b0} >> 1 << 1;
        span    = {wlen, 1'b0};
        quarter = (TW+1)'(wlen >> 1);
        shift   = quarter * (TW+1)'(phase);
        pos     = ({1'b0, tcnt} + span - shift) & (span - (TW+1)'(1));
        pclk    = pos < {1'b0, wlen};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt <= '0;
        end else if ({1'b0, tcnt} == span - (TW+1)'(1)) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + TW'(1);
        end
    end

    // R9: the tick counter stays inside one word period
    p_tcnt_range_r9: assert property (@(posedge clk) disable iff (rst)
        {1'b0, tcnt} < span);

endmodule

// File: rtl/cmi_rx_deser.sv
module cmi_rx_deser
    import cmi_rx_pkg::*;
#(
    parameter int unsigned MAX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic             cmi_en,
    input  logic             loop_en,
    input  logic [1:0]       width_sel,
    input  logic [1:0]       phase_sel,
    output logic [MAX_W-1:0] word_out,
    output logic             viol_out,
    output logic             pclk_out,
    output logic             line_out
);
    localparam int unsigned LW = $clog2(MAX_W) + 1;

    logic [1:0]    wcode_q;
    logic [1:0]    phase_q;
    logic          line_q;
    logic [LW-1:0] wlen;
    logic [LW-1:0] tcnt;
    logic          pk_done;
    logic          word_viol;
    dbit_t         dbit;

    always_comb begin
        if (width_of(wcode_q) > MAX_W) wlen = LW'(MAX_W);
        else                           wlen = LW'(width_of(wcode_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcode_q <= width_sel;
            phase_q <= phase_sel;
            line_q  <= 1'b0;
        end else begin
            line_q  <= line_in;
        end
    end

    cmi_sym_dec i_dec (
        .clk    (clk),
        .rst    (rst),
        .line_in(line_in),
        .cmi_en (cmi_en),
        .dbit   (dbit)
    );

    cmi_word_pack #(.MAX_W(MAX_W)) i_pack (
        .clk      (clk),
        .rst      (rst),
        .dbit     (dbit),
        .wlen     (wlen),
        .done     (pk_done),
        .word_out (word_out),
        .word_viol(word_viol)
    );

    cmi_pclk_gen #(.MAX_W(MAX_W)) i_pclk (
        .clk  (clk),
        .rst  (rst),
        .wlen (wlen),
        .phase(phase_q),
        .tcnt (tcnt),
        .pclk (pclk_out)
    );

    assign viol_out = word_viol & cmi_en;
    assign line_out = loop_en & line_q;

    // R4: word completion lands on the last tick of the clock period
    p_word_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        pk_done |-> ({1'b0, tcnt} == {wlen, 1'b0} - (LW+1)'(1)));

    // R10: remote loop echoes the previous sample
    p_loop_echo_r10: assert property (@(posedge clk) disable iff (rst)
        (loop_en && !$past(rst)) |-> (line_out == $past(line_in)));

    // R1: outputs are quiet on the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (word_out == '0) && !viol_out);

endmodule

// File: tb/test_cmi_rx_deser.sv
`timescale 1ns/1ps
module test_cmi_rx_deser;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_in = 1'b0;
    logic       cmi_en = 1'b1;
    logic       loop_en = 1'b0;
    logic [1:0] width_sel = 2'd2;
    logic [1:0] phase_sel = 2'd0;
    logic [7:0] word_out;
    logic       viol_out;
    logic       pclk_out;
    logic       line_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmi_rx_deser #(.MAX_W(8)) i_cmi_rx_deser (
        .clk(clk), .rst(rst), .line_in(line_in), .cmi_en(cmi_en),
        .loop_en(loop_en), .width_sel(width_sel), .phase_sel(phase_sel),
        .word_out(word_out), .viol_out(viol_out), .pclk_out(pclk_out),
        .line_out(line_out)
    );

    // pair code: bit0 = first sample, bit1 = second sample
    localparam logic [1:0] SZ = 2'b10;  // (0,1) zero
    localparam logic [1:0] SH = 2'b11;  // (1,1) one high
    localparam logic [1:0] SL = 2'b00;  // (0,0) one low
    localparam logic [1:0] SV = 2'b01;  // (1,0) bad pair

    typedef struct packed {
        logic [1:0]  w;
        logic        cmi;
        logic [15:0] smp;
        logic [7:0]  exp_word;
        logic        exp_viol;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd2, 1'b1, {SZ,SZ,SL,SH,SZ,SL,SZ,SH}, 8'h35, 1'b0},
        '{2'd2, 1'b1, {SZ,SZ,SZ,SZ,SZ,SZ,SH,SH}, 8'h03, 1'b1},
        '{2'd2, 1'b1, {SZ,SZ,SZ,SZ,SZ,SV,SZ,SZ}, 8'h00, 1'b1},
        '{2'd1, 1'b1, {SZ,SZ,SZ,SZ,SZ,SH,SZ,SL}, 8'h05, 1'b0},
        '{2'd0, 1'b1, {SZ,SZ,SZ,SZ,SZ,SZ,SH,SZ}, 8'h02, 1'b0},
        '{2'd2, 1'b0, {SV,SH,SH,SL,SZ,SV,SH,SH}, 8'hE7, 1'b0},
        '{2'd1, 1'b1, {SZ,SZ,SZ,SZ,SZ,SL,SZ,SL}, 8'h05, 1'b1},
        '{2'd3, 1'b1, {SZ,SZ,SZ,SZ,SZ,SZ,SZ,SZ}, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] w, input logic [1:0] ph, input logic c);
        @(negedge clk);
        rst = 1'b1; width_sel = w; phase_sel = ph; cmi_en = c; line_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_pair(input logic [1:0] p);
        line_in = p[0];
        @(negedge clk);
        line_in = p[1];
        @(negedge clk);
    endtask

    task automatic pclk_scan(input logic [1:0] w, input int wid, input logic [1:0] ph);
        do_reset(w, ph, 1'b1);
        for (int k = 0; k < 4 * wid; k++) begin
            int pos;
            pos = ((k - int'(ph) * (wid / 2)) % (2 * wid) + 2 * wid) % (2 * wid);
            chk("R9 pclk phase", 32'(pclk_out), 32'(pos < wid));
            line_in = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R4 act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(2'd2, 2'd0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 word in reset", 32'(word_out), 32'h0);
        chk("R1 viol in reset", 32'(viol_out), 32'h0);
        chk("R1 line_out in reset", 32'(line_out), 32'h0);
        chk("R1 pclk in reset", 32'(pclk_out), 32'h1);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int e = 0; e < 8; e++) begin
            int wid;
            wid = (VECS[e].w == 2'd0) ? 2 : (VECS[e].w == 2'd1) ? 4 : 8;
            do_reset(VECS[e].w, 2'd0, VECS[e].cmi);
            for (int p = 0; p < wid; p++) send_pair(VECS[e].smp[2*p +: 2]);
            chk("R2/R4 decoded word", 32'(word_out), 32'(VECS[e].exp_word));
            chk("R5/R6/R8 word violation", 32'(viol_out), 32'(VECS[e].exp_viol));
            for (int p = 0; p < wid; p++) send_pair(SZ);
            chk("R4 clean follow word", 32'(word_out), 32'h0);
            chk("R7 flag clears next word", 32'(viol_out), 32'h0);
        end

        // R3: upper lanes zero and first bit in bit 0 at width 2
        do_reset(2'd0, 2'd0, 1'b1);
        send_pair(SH); send_pair(SZ);
        chk("R3 first bit at bit 0", 32'(word_out), 32'h01);

        // R4: word changes only after edge 2W-1
        do_reset(2'd1, 2'd0, 1'b1);
        send_pair(SH); send_pair(SL); send_pair(SH);
        line_in = 1'b0; @(negedge clk);
        chk("R4 no update mid last pair", 32'(word_out), 32'h0);
        line_in = 1'b0; @(negedge clk);
        chk("R4 update after last pair", 32'(word_out), 32'h0F);

        // R8: disabling decode mid-stream silences the flag
        do_reset(2'd0, 2'd0, 1'b1);
        send_pair(SV); send_pair(SZ);
        chk("R5 bad pair flagged", 32'(viol_out), 32'h1);
        cmi_en = 1'b0;
        #1;
        chk("R8 flag low when disabled", 32'(viol_out), 32'h0);

        // R6: re-enable restarts level memory
        do_reset(2'd0, 2'd0, 1'b1);
        send_pair(SH); send_pair(SZ);
        cmi_en = 1'b0; send_pair(SZ); cmi_en = 1'b1; send_pair(SZ);
        send_pair(SH); send_pair(SZ);
        chk("R6 first one after enable", 32'(viol_out), 32'h0);

        // R9: parallel clock offsets
        for (int ph = 0; ph < 4; ph++) pclk_scan(2'd1, 4, 2'(ph));
        pclk_scan(2'd0, 2, 2'd3);
        pclk_scan(2'd2, 8, 2'd1);

        // R10: remote loop
        do_reset(2'd2, 2'd0, 1'b1);
        loop_en = 1'b1; line_in = 1'b1; @(negedge clk);
        chk("R10 loop echoes one", 32'(line_out), 32'h1);
        line_in = 1'b0; @(negedge clk);
        chk("R10 loop echoes zero", 32'(line_out), 32'h0);
        loop_en = 1'b0; line_in = 1'b1; @(negedge clk);
        chk("R10 loop off is zero", 32'(line_out), 32'h0);

        // R11: config changes after reset are ignored
        do_reset(2'd0, 2'd0, 1'b1);
        width_sel = 2'd2; phase_sel = 2'd3;
        chk("R11 pclk keeps phase 0", 32'(pclk_out), 32'h1);
        send_pair(SZ); send_pair(SH);
        chk("R11 width stays two", 32'(word_out), 32'h02);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule